// File: doc/BRIEF.md
# Dual-Comparator Timer with PWM Output

This block is a 10-bit up-counter with two compare values, A and P, that drive one output pin and two match flags. A small set of control inputs picks one of three operating modes. In compare-match output mode, a match on A can set, clear or toggle the pin. In PWM mode the counter produces a periodic waveform, and one register sets the period while the other sets the duty. In timer/counter mode the counter, clearing and flags run as normal while the pin stays low.

Compare value A is 10 bits and is checked against the whole count. Compare value P is 3 bits and picks one of eight 128-count blocks. P matches on the last count of block P-1, so a non-zero P gives a period of P×128 counts. A P of zero matches at count 1023, so the counter runs its full 1024-count range. Outside PWM mode, a select input picks which match returns the counter to zero. The match flags stay set until their clear pulse arrives.

Top module: `dual_cmp_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, both flags and the internal output level are cleared, so after reset with mode 00 and `out_inv`=0 the pin reads 0.
- R2: With `run_en` low the count is held at 0. With `run_en` high the count rises by one per clock and wraps from 1023 to 0 unless a clear applies.
- R3: The P match occurs at count {P-1, 7'h7F}, using 3-bit wrap, so P=0 matches at 1023. Outside PWM mode with `clr_sel_a`=0, the count is 0 on the clock after a P match, which gives a period of P×128 counts, or 1024 when P=0.
- R4: Outside PWM mode with `clr_sel_a`=1, the count is 0 on the clock after it equals A, which gives a period of A+1 counts.
- R5: In mode 00 (compare-match output) the internal level follows `out_ctl` while the counter is stopped or the mode is not 00. On an A match while running, `match_act` acts on the level: 00 holds it, 01 drives it low, 10 drives it high and 11 toggles it. The pin equals the level XOR `out_inv`.
- R6: In mode 01 (PWM), `clr_sel_a` is ignored. With `role_swap`=0, P sets the period as in R3 and the duty threshold is A. With `role_swap`=1, the count clears after it equals A (period A+1) and the duty threshold is P×128.
- R7: In PWM mode the waveform is active while running and count < duty threshold. The active level is `out_ctl` and the inactive level is its inverse, and the pin is that level XOR `out_inv`. While stopped the waveform is inactive.
- R8: In modes 10 and 11 (timer/counter) the pin is 0 whatever `out_ctl` and `out_inv` are, and the counter, clearing and flags behave as outside PWM mode.
- R9: Each flag is set on the clock after its comparator matches while running, whichever clear source is selected. A flag stays set until a one-cycle clear pulse. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counter run enable; low holds count at zero |
| mode | input | 2 | 00 compare-match output, 01 PWM, 10/11 timer/counter |
| out_ctl | input | 1 | Initial level (mode 00) or active level (PWM) |
| out_inv | input | 1 | Invert the pin in modes 00 and 01 |
| role_swap | input | 1 | PWM: 0 P period / A duty, 1 A period / P duty |
| clr_sel_a | input | 1 | Non-PWM clear source: 1 A match, 0 P match |
| match_act | input | 2 | Level action on A match in mode 00 |
| cmp_a | input | 10 | Compare value A |
| cmp_p | input | 3 | Compare value P (128-count blocks) |
| flag_clr_a | input | 1 | One-cycle clear of the A flag |
| flag_clr_p | input | 1 | One-cycle clear of the P flag |
| pin_out | output | 1 | Timer output pin |
| flag_a | output | 1 | Sticky A-match flag |
| flag_p | output | 1 | Sticky P-match flag |
| count | output | 10 | Current counter value |

## Verification
The assertions check these rules on every cycle:
- The count stays at zero while stopped, and otherwise it either steps by one or returns to zero.
- The A flag is set after any A match and stays set until its clear pulse.
- Outside PWM, an A-selected clear returns the count to zero.
- The pin stays low in timer/counter mode.

Some behaviour is only visible over a whole sequence, and the bench scenarios cover it. This includes periods set by P, including the full-range case where P is zero, and the output actions and toggling on A matches. It also includes the PWM duty edge with either register role, polarity inversion, and flag clear pulses that meet a new match. A behavioural reference model follows every cycle of these scenarios.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    parameter int unsigned TMR_CNT_W = 10;
    parameter int unsigned TMR_P_W   = 3;
    parameter int unsigned TMR_NFLAG = 2;

    typedef enum logic [1:0] {
        MODE_CMP   = 2'b00,
        MODE_PWM   = 2'b01,
        MODE_TMR_A = 2'b10,
        MODE_TMR_B = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef struct packed {
        mode_e mode;
        logic  out_ctl;
        logic  out_inv;
        logic  role_swap;
        logic  clr_sel_a;
        act_e  act;
    } ctl_t;

    function automatic logic apply_act(input act_e act, input logic cur);
        case (act)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import cmp_timer_pkg::*;
#(
    parameter int unsigned CNT_W = TMR_CNT_W,
    parameter int unsigned P_W   = TMR_P_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  mode_e            mode,
    input  logic             role_swap,
    input  logic             clr_sel_a,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [P_W-1:0]   cmp_p,
    output logic [CNT_W-1:0] count,
    output logic             hit_a,
    output logic             hit_p
);
    localparam int unsigned LOW_W = CNT_W - P_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] p_end;
    logic             clr_now;

    // P ends on the last count of block P-1; P=0 wraps to the final block.
    assign p_end = {cmp_p - P_W'(1), {LOW_W{1'b1}}};
    assign hit_a = run_en && (cnt_q == cmp_a);
    assign hit_p = run_en && (cnt_q == p_end);

    always_comb begin
        case (mode)
            MODE_PWM: clr_now = role_swap ? hit_a : hit_p;
            default:  clr_now = clr_sel_a ? hit_a : hit_p;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            cnt_q <= '0;
        end else if (clr_now) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/tmr_output.sv
module tmr_output
    import cmp_timer_pkg::*;
#(
    parameter int unsigned CNT_W = TMR_CNT_W,
    parameter int unsigned P_W   = TMR_P_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  mode_e            mode,
    input  logic             out_ctl,
    input  logic             out_inv,
    input  logic             role_swap,
    input  act_e             act,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [P_W-1:0]   cmp_p,
    input  logic             hit_a,
    output logic             pin
);
    localparam int unsigned LOW_W = CNT_W - P_W;

    logic             lvl_q;
    logic [CNT_W-1:0] duty_lim;
    logic             pwm_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
        end else if (!run_en || mode != MODE_CMP) begin
            lvl_q <= out_ctl;
        end else if (hit_a) begin
            lvl_q <= apply_act(act, lvl_q);
        end
    end

    assign duty_lim = role_swap ? {cmp_p, {LOW_W{1'b0}}} : cmp_a;
    assign pwm_on   = run_en && (count < duty_lim);

    always_comb begin
        case (mode)
            MODE_CMP: pin = lvl_q ^ out_inv;
            MODE_PWM: pin = (pwm_on ? out_ctl : ~out_ctl) ^ out_inv;
            default:  pin = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
    import cmp_timer_pkg::*;
#(
    parameter int unsigned NFLAG = TMR_NFLAG
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set_i,
    input  logic [NFLAG-1:0] clr_i,
    output logic [NFLAG-1:0] flag_o
);
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                f_q <= 1'b0;
            end else if (set_i[g]) begin
                f_q <= 1'b1;
            end else if (clr_i[g]) begin
                f_q <= 1'b0;
            end
        end
        assign flag_o[g] = f_q;
    end

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int unsigned CNT_W = TMR_CNT_W,
    parameter int unsigned P_W   = TMR_P_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [1:0]       mode,
    input  logic             out_ctl,
    input  logic             out_inv,
    input  logic             role_swap,
    input  logic             clr_sel_a,
    input  logic [1:0]       match_act,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [P_W-1:0]   cmp_p,
    input  logic             flag_clr_a,
    input  logic             flag_clr_p,
    output logic             pin_out,
    output logic             flag_a,
    output logic             flag_p,
    output logic [CNT_W-1:0] count
);
    ctl_t       ctl;
    logic       hit_a;
    logic       hit_p;
    logic [1:0] flags;

    assign ctl = '{mode:      mode_e'(mode),
                   out_ctl:   out_ctl,
                   out_inv:   out_inv,
                   role_swap: role_swap,
                   clr_sel_a: clr_sel_a,
                   act:       act_e'(match_act)};

    tmr_counter #(.CNT_W(CNT_W), .P_W(P_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .mode      (ctl.mode),
        .role_swap (ctl.role_swap),
        .clr_sel_a (ctl.clr_sel_a),
        .cmp_a     (cmp_a),
        .cmp_p     (cmp_p),
        .count     (count),
        .hit_a     (hit_a),
        .hit_p     (hit_p)
    );

    tmr_output #(.CNT_W(CNT_W), .P_W(P_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .mode      (ctl.mode),
        .out_ctl   (ctl.out_ctl),
        .out_inv   (ctl.out_inv),
        .role_swap (ctl.role_swap),
        .act       (ctl.act),
        .count     (count),
        .cmp_a     (cmp_a),
        .cmp_p     (cmp_p),
        .hit_a     (hit_a),
        .pin       (pin_out)
    );

    tmr_flags #(.NFLAG(2)) u_flg (
        .clk    (clk),
        .rst    (rst),
        .set_i  ({hit_p, hit_a}),
        .clr_i  ({flag_clr_p, flag_clr_a}),
        .flag_o (flags)
    );

    assign flag_a = flags[0];
    assign flag_p = flags[1];

endmodule

// File: rtl/dual_cmp_timer_chk.sv
module dual_cmp_timer_chk #(
    parameter int unsigned CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             run_en,
    input logic [1:0]       mode,
    input logic             clr_sel_a,
    input logic [CNT_W-1:0] cmp_a,
    input logic             flag_clr_a,
    input logic             pin_out,
    input logic             flag_a,
    input logic [CNT_W-1:0] count
);
    // R2: a stopped counter reads zero on the next cycle
    assert_stop_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (count == '0));

    // R2: a running counter steps by one or returns to zero
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        run_en |=> ((count == '0) || (count == $past(count) + 1'b1)));

    // R4: A-selected clear outside PWM
    assert_clear_on_a_R4: assert property (@(posedge clk) disable iff (rst)
        (run_en && mode != 2'b01 && clr_sel_a && count == cmp_a) |=> (count == '0));

    // R9: an A match raises the flag
    assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
        (run_en && count == cmp_a) |=> flag_a);

    // R9: the flag holds until a clear pulse
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (flag_a && !flag_clr_a) |=> flag_a);

    // R8: timer/counter mode keeps the pin low
    assert_timer_pin_low_R8: assert property (@(posedge clk) disable iff (rst)
        mode[1] |-> !pin_out);

endmodule

bind dual_cmp_timer dual_cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .mode       (mode),
    .clr_sel_a  (clr_sel_a),
    .cmp_a      (cmp_a),
    .flag_clr_a (flag_clr_a),
    .pin_out    (pin_out),
    .flag_a     (flag_a),
    .count      (count)
);

// File: tb/tb_dual_cmp_timer.sv
`timescale 1ns/1ps
module tb_dual_cmp_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       out_ctl = 1'b0;
    logic       out_inv = 1'b0;
    logic       role_swap = 1'b0;
    logic       clr_sel_a = 1'b0;
    logic [1:0] match_act = 2'b00;
    logic [9:0] cmp_a = 10'd0;
    logic [2:0] cmp_p = 3'd0;
    logic       flag_clr_a = 1'b0;
    logic       flag_clr_p = 1'b0;
    logic       pin_out, flag_a, flag_p;
    logic [9:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_cmp_timer dut (
        .clk(clk), .rst(rst), .run_en(run_en), .mode(mode),
        .out_ctl(out_ctl), .out_inv(out_inv), .role_swap(role_swap),
        .clr_sel_a(clr_sel_a), .match_act(match_act), .cmp_a(cmp_a),
        .cmp_p(cmp_p), .flag_clr_a(flag_clr_a), .flag_clr_p(flag_clr_p),
        .pin_out(pin_out), .flag_a(flag_a), .flag_p(flag_p), .count(count)
    );

    // Behavioural reference state
    int m_cnt = 0;
    bit m_lvl = 0;
    bit m_fa = 0;
    bit m_fp = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_pin();
        int duty;
        bit on;
        case (mode)
            2'b00: return m_lvl ^ out_inv;
            2'b01: begin
                duty = role_swap ? int'(cmp_p) * 128 : int'(cmp_a);
                on = run_en && (m_cnt < duty);
                return (on ? out_ctl : !out_ctl) ^ out_inv;
            end
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_lvl = 0; m_fa = 0; m_fp = 0;
        end else begin
            int pend;
            bit ha, hp, clr;
            pend = ((int'(cmp_p) + 7) % 8) * 128 + 127;
            ha = run_en && (m_cnt == int'(cmp_a));
            hp = run_en && (m_cnt == pend);
            if (mode == 2'b01) clr = role_swap ? ha : hp;
            else               clr = clr_sel_a ? ha : hp;
            if (!run_en || mode != 2'b00) m_lvl = out_ctl;
            else if (ha) begin
                case (match_act)
                    2'b01: m_lvl = 0;
                    2'b10: m_lvl = 1;
                    2'b11: m_lvl = !m_lvl;
                    default: ;
                endcase
            end
            m_fa = ha | (m_fa & !flag_clr_a);
            m_fp = hp | (m_fp & !flag_clr_p);
            if (!run_en || clr) m_cnt = 0;
            else m_cnt = (m_cnt + 1) % 1024;
        end
        #1;
        if (!done) begin
            check(int'(count) == m_cnt, "R2 model count", int'(count), m_cnt);
            check(flag_a == m_fa, "R9 model flag_a", flag_a, m_fa);
            check(flag_p == m_fp, "R9 model flag_p", flag_p, m_fp);
            check(pin_out == exp_pin(),
                  mode == 2'b00 ? "R5 model pin" : (mode == 2'b01 ? "R7 model pin" : "R8 model pin"),
                  pin_out, exp_pin());
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait until the count shows v just after an edge
    task automatic wait_cnt(input int v, input string tag);
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            if (int'(count) == v) return;
        end
        check(0, tag, int'(count), v);
    endtask

    initial begin
        cyc(3);
        #1;
        check(count == 0 && !flag_a && !flag_p && !pin_out, "R1 reset state",
              {flag_a, flag_p, pin_out}, 0);
        rst = 0;

        // Compare-match: initial high, toggle on A, clear on A
        @(negedge clk);
        out_ctl = 1; clr_sel_a = 1; cmp_a = 10'd9; cmp_p = 3'd1; match_act = 2'b11;
        cyc(2);
        check(pin_out == 1, "R5 initial level while stopped", pin_out, 1);
        run_en = 1;
        wait_cnt(9, "R4 reach A");
        check(pin_out == 1, "R5 level before A match", pin_out, 1);
        @(posedge clk); #1;
        check(count == 0, "R4 clear after A", count, 0);
        check(pin_out == 0, "R5 toggle on A match", pin_out, 0);
        check(flag_a == 1, "R9 A flag set", flag_a, 1);
        wait_cnt(9, "R4 second A");
        @(posedge clk); #1;
        check(pin_out == 1, "R5 second toggle", pin_out, 1);

        // Inversion and drive-low action
        @(negedge clk); out_inv = 1; match_act = 2'b01;
        wait_cnt(9, "R5 reach A");
        @(posedge clk); #1;
        check(pin_out == 1, "R5 drive low then inverted", pin_out, 1);

        // P clear with P=1 -> period 128; both flags raised
        @(negedge clk); out_inv = 0; clr_sel_a = 0; match_act = 2'b10;
        wait_cnt(127, "R3 reach P end");
        @(posedge clk); #1;
        check(count == 0, "R3 clear after P match", count, 0);
        check(flag_p == 1 && flag_a == 1, "R9 both flags with P clear", {flag_a, flag_p}, 3);
        check(pin_out == 1, "R5 drive high action", pin_out, 1);

        // Flag clear pulse with counter stopped
        @(negedge clk); run_en = 0;
        @(negedge clk); flag_clr_a = 1; flag_clr_p = 1;
        @(negedge clk); flag_clr_a = 0; flag_clr_p = 0;
        #1;
        check(flag_a == 0 && flag_p == 0, "R9 clear pulse", {flag_a, flag_p}, 0);

        // Clear pulse coinciding with a new A match: set wins
        @(negedge clk); cmp_a = 10'd4; run_en = 1;
        cyc(4);
        flag_clr_a = 1;
        @(negedge clk); flag_clr_a = 0;
        #1;
        check(flag_a == 1, "R9 set wins over clear", flag_a, 1);

        // P=0 -> full range 1024
        @(negedge clk); cmp_p = 3'd0; cmp_a = 10'd600; match_act = 2'b00;
        wait_cnt(1023, "R3 reach 1023");
        @(posedge clk); #1;
        check(count == 0, "R3 overflow clear with P zero", count, 0);

        // PWM, P period, A duty, clr_sel_a ignored
        @(negedge clk); run_en = 0; mode = 2'b01; cmp_p = 3'd1; cmp_a = 10'd32;
        clr_sel_a = 1; out_ctl = 1; out_inv = 0; role_swap = 0;
        @(negedge clk); run_en = 1;
        wait_cnt(10, "R7 reach 10");
        check(pin_out == 1, "R7 active below duty", pin_out, 1);
        wait_cnt(50, "R6 pass A with clr_sel_a ignored");
        check(pin_out == 0, "R7 inactive above duty", pin_out, 0);
        wait_cnt(127, "R6 reach P period end");
        @(posedge clk); #1;
        check(count == 0, "R6 P sets period", count, 0);

        // PWM swapped: A period 200, duty 128, inverted active-high
        @(negedge clk); role_swap = 1; cmp_a = 10'd199; out_inv = 1;
        wait_cnt(100, "R6 swapped duty region");
        check(pin_out == 0, "R7 inverted active", pin_out, 0);
        wait_cnt(150, "R6 swapped past duty");
        check(pin_out == 1, "R7 inverted inactive", pin_out, 1);
        wait_cnt(199, "R6 reach A period end");
        @(posedge clk); #1;
        check(count == 0, "R6 A sets period when swapped", count, 0);

        // Timer/counter mode: pin low, counter and flags still work
        @(negedge clk); mode = 2'b10; out_ctl = 1; out_inv = 1; clr_sel_a = 1;
        cmp_a = 10'd20; flag_clr_a = 1;
        @(negedge clk); flag_clr_a = 0;
        wait_cnt(20, "R8 reach A");
        check(pin_out == 0, "R8 pin low in timer mode", pin_out, 0);
        @(posedge clk); #1;
        check(count == 0 && flag_a == 1, "R8 clear and flag in timer mode", {count, flag_a}, 1);
        @(negedge clk); mode = 2'b11;
        cyc(30);
        #1;
        check(pin_out == 0, "R8 pin low in mode 11", pin_out, 0);

        // Back to compare mode, stopped: level reloads from out_ctl
        @(negedge clk); mode = 2'b00; run_en = 0; out_ctl = 0; out_inv = 0;
        @(negedge clk);
        check(pin_out == 0, "R5 reload initial low", pin_out, 0);
        check(count == 0, "R2 held at zero while stopped", count, 0);

        cyc(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule